// File: doc/BRIEF.md
# Audio Serial Output Formatter

This block places one left and one right 24-bit audio sample per frame on a single serial data line. A bit clock and a frame (LR) clock pace the line, and both are sampled in the block's own system clock domain. Because the block only reacts to their edges, the two clocks may be generated elsewhere on the chip or may arrive from an external controller.

A two-bit format input selects one of four framings: left-justified, I2S, 24-bit right-justified, or 20-bit right-justified. The block measures the length of each half-frame. A frame of 48 or 64 bit clocks is accepted. Any other length is reported on a frame-error flag. A zero-force input sends all-zero data while the frame timing keeps running, for example during reset or after loss of synchronisation. An output-disable input drops the tri-state enable of the data line.

Top module: `audio_ser_fmt`

## Requirements
- R1: With `fmt_i` = 2'b00 (left-justified), the sample MSB is in slot 0 of the half-frame, counting slots from the bit-clock falling edge on which the LR clock toggles. The 24 bits follow MSB first, and the remaining slots are zero. The half with LR low carries `left_i` and the half with LR high carries `right_i`.
- R2: With `fmt_i` = 2'b01 (I2S), the MSB is in slot 1. In a 32-slot half, slot 0 and slots 25 to 31 are zero. In a 24-slot half, bit 0 of the word moves into slot 0 of the following half.
- R3: With `fmt_i` = 2'b10 (24-bit right-justified), bit 0 of the sample is in the last slot of the half and the leading slots are zero.
- R4: With `fmt_i` = 2'b11 (20-bit right-justified), only sample bits 23 to 4 are sent, with bit 4 in the last slot of the half and the leading slots zero.
- R5: `sdata_o` changes only in the system-clock cycle that first samples `bclk_i` low after a high sample. It holds its value through all other cycles.
- R6: Half-frames of 24 and 32 bit clocks (48- and 64-clock frames) are both supported. The justification of each half uses the length measured for the preceding half.
- R7: When a half-frame that has just ended is neither 24 nor 32 slots long, `frame_err_o` goes high at the LR edge that ends it. This includes a 32-clock frame. The flag goes low at the next edge that ends a valid half. The first LR edge after reset never raises the flag.
- R8: While `zero_i` is high, every bit driven on `sdata_o` is zero.
- R9: `sdata_oe_o` is low in the cycle after `dis_i` is sampled high, and high in the cycle after `dis_i` is sampled low.
- R10: The outgoing sample is captured at the LR edge that opens its half. Changes on `left_i` or `right_i` later in that half do not alter the bits sent.
- R11: In reset, `sdata_o`, `sdata_oe_o` and `frame_err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock, sampled in clk_i domain |
| lrck_i | input | 1 | Frame (LR) clock, sampled with bclk_i |
| fmt_i | input | 2 | Format select |
| left_i | input | 24 | Left-channel sample |
| right_i | input | 24 | Right-channel sample |
| zero_i | input | 1 | Force all data bits to zero |
| dis_i | input | 1 | Output disable (power-down) |
| sdata_o | output | 1 | Serial data, updated after bit-clock falling edges |
| sdata_oe_o | output | 1 | Tri-state enable for sdata_o |
| frame_err_o | output | 1 | Last completed half-frame had an unsupported length |

## Verification
The assertions check on every cycle that the data line moves only at bit-clock falling edges, that zero-force blanks each new bit, that the enable tracks the disable input, and that the error flag moves only at LR edges. Bit placement for each format and length, the I2S spill into the next half, the mid-half sample change, and the raising and clearing of the frame error all depend on the frame sequence. Only the bench's scenarios, which compare whole captured half-frames against independently built patterns, can show these.

// File: rtl/audio_fmt_pkg.sv
package audio_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_LJ       = 2'b00,
    FMT_I2S      = 2'b01,
    FMT_RJ       = 2'b10,
    FMT_RJ_SHORT = 2'b11
  } fmt_e;
endpackage

// File: rtl/afs_edge.sv
module afs_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic fall_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  assign fall_o = bclk_q & ~bclk_i;
endmodule

// File: rtl/afs_tracker.sv
module afs_tracker #(
  parameter int SAMPLE_W   = 24,
  parameter int SLOT_W     = 6,
  parameter int HALF_LONG  = 32,
  parameter int HALF_SHORT = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                lrck_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [SLOT_W-1:0]   slot_d_o,
  output logic [SAMPLE_W-1:0] word_d_o,
  output logic [SLOT_W-1:0]   half_len_d_o,
  output logic                prev_lsb_d_o,
  output logic                frame_err_o
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  logic                lr_q, lr_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [SAMPLE_W-1:0] word_q, word_d;
  logic [SLOT_W-1:0]   half_len_q, half_len_d;
  logic                prev_lsb_q, prev_lsb_d;
  logic                synced_q, synced_d;
  logic                err_q, err_d;
  logic                lr_edge, len_ok;
  int                  ended_len;

  always_comb begin
    lr_edge    = fall_i && (lrck_i != lr_q);
    ended_len  = int'(slot_q) + 1;
    len_ok     = (ended_len == HALF_LONG) || (ended_len == HALF_SHORT);
    lr_d       = fall_i ? lrck_i : lr_q;
    slot_d     = slot_q;
    word_d     = word_q;
    half_len_d = half_len_q;
    prev_lsb_d = prev_lsb_q;
    synced_d   = synced_q;
    err_d      = err_q;
    if (lr_edge) begin
      slot_d     = '0;
      word_d     = lrck_i ? right_i : left_i;
      prev_lsb_d = word_q[0];
      synced_d   = 1'b1;
      if (synced_q) begin
        err_d = !len_ok;
        if (len_ok) half_len_d = SLOT_W'(ended_len);
      end
    end else if (fall_i) begin
      // saturate so an over-long half still reads as invalid
      slot_d = (slot_q == SLOT_MAX) ? slot_q : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q       <= 1'b0;
      slot_q     <= '0;
      word_q     <= '0;
      half_len_q <= SLOT_W'(HALF_LONG);
      prev_lsb_q <= 1'b0;
      synced_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      lr_q       <= lr_d;
      slot_q     <= slot_d;
      word_q     <= word_d;
      half_len_q <= half_len_d;
      prev_lsb_q <= prev_lsb_d;
      synced_q   <= synced_d;
      err_q      <= err_d;
    end
  end

  assign slot_d_o     = slot_d;
  assign word_d_o     = word_d;
  assign half_len_d_o = half_len_d;
  assign prev_lsb_d_o = prev_lsb_d;
  assign frame_err_o  = err_q;
endmodule

// File: rtl/afs_bitsel.sv
module afs_bitsel
  import audio_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 20,
  parameter int SLOT_W   = 6
) (
  input  logic [1:0]          fmt_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [SLOT_W-1:0]   half_len_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                prev_lsb_i,
  output logic                bit_o
);
  localparam int DROP = SAMPLE_W - SHORT_W;

  int                  s, hl, idx;
  logic [SAMPLE_W-1:0] sh;

  always_comb begin
    s     = int'(slot_i);
    hl    = int'(half_len_i);
    bit_o = 1'b0;
    sh    = '0;
    unique case (fmt_i)
      FMT_LJ:       idx = SAMPLE_W - 1 - s;
      FMT_I2S:      idx = SAMPLE_W - s;
      FMT_RJ:       idx = hl - 1 - s;
      FMT_RJ_SHORT: idx = hl - 1 - s + DROP;
      default:      idx = -1;
    endcase
    if (idx >= 0 && idx < SAMPLE_W && s < hl) begin
      sh    = word_i >> idx;
      bit_o = sh[0];
    end
    // short half in I2S: last bit of the previous word spills into slot 0
    if (fmt_i == FMT_I2S && s == 0 && hl == SAMPLE_W) bit_o = prev_lsb_i;
  end
endmodule

// File: rtl/audio_ser_fmt.sv
module audio_ser_fmt #(
  parameter int SAMPLE_W   = 24,
  parameter int SHORT_W    = 20,
  parameter int HALF_LONG  = 32,
  parameter int HALF_SHORT = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic [1:0]          fmt_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                zero_i,
  input  logic                dis_i,
  output logic                sdata_o,
  output logic                sdata_oe_o,
  output logic                frame_err_o
);
  localparam int SLOT_W = $clog2(2 * HALF_LONG);

  logic                fall;
  logic [SLOT_W-1:0]   slot_d, half_len_d;
  logic [SAMPLE_W-1:0] word_d;
  logic                prev_lsb_d, bit_nxt;
  logic                sdata_q, oe_q;

  afs_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bclk_i(bclk_i),
    .fall_o(fall)
  );

  afs_tracker #(
    .SAMPLE_W  (SAMPLE_W),
    .SLOT_W    (SLOT_W),
    .HALF_LONG (HALF_LONG),
    .HALF_SHORT(HALF_SHORT)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall),
    .lrck_i      (lrck_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .slot_d_o    (slot_d),
    .word_d_o    (word_d),
    .half_len_d_o(half_len_d),
    .prev_lsb_d_o(prev_lsb_d),
    .frame_err_o (frame_err_o)
  );

  afs_bitsel #(
    .SAMPLE_W(SAMPLE_W),
    .SHORT_W (SHORT_W),
    .SLOT_W  (SLOT_W)
  ) u_sel (
    .fmt_i     (fmt_i),
    .slot_i    (slot_d),
    .half_len_i(half_len_d),
    .word_i    (word_d),
    .prev_lsb_i(prev_lsb_d),
    .bit_o     (bit_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= ~dis_i;
      if (fall) sdata_q <= zero_i ? 1'b0 : bit_nxt;
    end
  end

  assign sdata_o    = sdata_q;
  assign sdata_oe_o = oe_q;
endmodule

// File: rtl/audio_ser_fmt_chk.sv
module audio_ser_fmt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_i,
  input logic lrck_i,
  input logic zero_i,
  input logic dis_i,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic frame_err_o
);
  logic bclk_prev, lr_seen, fall_seen, lr_change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_prev <= 1'b0;
      lr_seen   <= 1'b0;
    end else begin
      bclk_prev <= bclk_i;
      if (fall_seen) lr_seen <= lrck_i;
    end
  end

  assign fall_seen = bclk_prev && !bclk_i;
  assign lr_change = fall_seen && (lrck_i != lr_seen);

  p_hold_between_falls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_seen |=> $stable(sdata_o));

  p_err_at_lr_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lr_change |=> $stable(frame_err_o));

  p_zero_force_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_i && fall_seen) |=> !sdata_o);

  p_oe_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !sdata_oe_o);

  p_oe_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_i |=> sdata_oe_o);
endmodule

bind audio_ser_fmt audio_ser_fmt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bclk_i     (bclk_i),
  .lrck_i     (lrck_i),
  .zero_i     (zero_i),
  .dis_i      (dis_i),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .frame_err_o(frame_err_o)
);

// File: tb/audio_ser_fmt_bench.sv
module audio_ser_fmt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1, lrck = 1'b1;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] left = '0, right = '0;
  logic        zero = 1'b0, dis = 1'b0;
  logic        sdata, oe, ferr;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  audio_ser_fmt u_audio_ser_fmt (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .lrck_i(lrck), .fmt_i(fmt),
    .left_i(left), .right_i(right), .zero_i(zero), .dis_i(dis),
    .sdata_o(sdata), .sdata_oe_o(oe), .frame_err_o(ferr)
  );

  // {fmt, half length, left, right}
  localparam logic [55:0] VEC [12] = '{
    {2'd0, 6'd32, 24'hA5C3F1, 24'h3C0FF7},
    {2'd0, 6'd24, 24'h81_2345, 24'hF0_0F01},
    {2'd1, 6'd32, 24'hC0FFEE, 24'h12_3457},
    {2'd1, 6'd24, 24'h9A_BCDF, 24'h65_4320},
    {2'd1, 6'd24, 24'h00_0001, 24'hFF_FFFE},
    {2'd2, 6'd32, 24'hDEAD_B5, 24'h7E_5A3B},
    {2'd2, 6'd24, 24'h5A_5A5B, 24'hA5_A5A4},
    {2'd3, 6'd32, 24'hFEDCBA, 24'h13_579B},
    {2'd3, 6'd24, 24'h80_000F, 24'h7F_FFF0},
    {2'd0, 6'd32, 24'h00_0001, 24'h80_0000},
    {2'd2, 6'd32, 24'h80_0000, 24'h00_0001},
    {2'd3, 6'd32, 24'hFF_FFFF, 24'h00_0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // expected half-frame, right aligned, first slot at bit hl-1
  function automatic logic [31:0] exp_half(input logic [1:0] f, input int hl,
                                           input logic [23:0] w, input logic plsb);
    logic [31:0] wx;
    wx = {8'h00, w};
    case (f)
      2'd0:    return wx << (hl - 24);
      2'd1:    return (hl == 32) ? (wx << 7) : ({31'd0, plsb} << 23) | (wx >> 1);
      2'd2:    return wx;
      default: return wx >> 4;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] f, input int hl);
    string r;
    case (f)
      2'd0:    r = "R1";
      2'd1:    r = "R2";
      2'd2:    r = "R3";
      default: r = "R4";
    endcase
    if (hl == 24) r = {r, " R6"};
    return r;
  endfunction

  task automatic run_half(input logic lr, input int hl, input int chg_at,
                          input logic [23:0] chg_val, output logic [31:0] cap);
    cap = '0;
    for (int s = 0; s < hl; s++) begin
      @(negedge clk); bclk = 1'b0; lrck = lr;
      if (s == chg_at) begin left = chg_val; right = chg_val; end
      @(negedge clk);
      @(negedge clk); bclk = 1'b1;
      @(negedge clk); cap = {cap[30:0], sdata};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] cap_l, cap_r, dummy;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 sdata", {31'd0, sdata}, 32'd0);
    chk("R11 oe", {31'd0, oe}, 32'd0);
    chk("R11 err", {31'd0, ferr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 oe on", {31'd0, oe}, 32'd1);

    // first edge after reset never flags (R7)
    run_half(1'b0, 32, -1, 24'h0, dummy);
    chk("R7 first edge", {31'd0, ferr}, 32'd0);
    run_half(1'b1, 32, -1, 24'h0, dummy);

    foreach (VEC[i]) begin
      automatic logic [1:0]  f  = VEC[i][55:54];
      automatic int          hl = int'(VEC[i][53:48]);
      automatic logic [23:0] l  = VEC[i][47:24];
      automatic logic [23:0] r  = VEC[i][23:0];
      fmt = f; left = l; right = r;
      run_half(1'b0, hl, -1, 24'h0, dummy);
      run_half(1'b1, hl, -1, 24'h0, dummy);
      run_half(1'b0, hl, -1, 24'h0, cap_l);
      run_half(1'b1, hl, -1, 24'h0, cap_r);
      chk({req_of(f, hl), " left"}, cap_l, exp_half(f, hl, l, r[0]));
      chk({req_of(f, hl), " right"}, cap_r, exp_half(f, hl, r, l[0]));
    end

    // R10 mid-half change ignored
    fmt = 2'b00; left = 24'hB4_C3D2; right = 24'h0F_1E2D;
    run_half(1'b0, 32, -1, 24'h0, dummy);
    run_half(1'b1, 32, -1, 24'h0, dummy);
    run_half(1'b0, 32, 6, 24'h55_AA55, cap_l);
    chk("R10 mid-half", cap_l, exp_half(2'b00, 32, 24'hB4_C3D2, 1'b0));

    // R8 zero force
    zero = 1'b1; left = 24'hFF_FFFF; right = 24'hFF_FFFF;
    run_half(1'b1, 32, -1, 24'h0, dummy);
    run_half(1'b0, 32, -1, 24'h0, cap_l);
    run_half(1'b1, 32, -1, 24'h0, cap_r);
    chk("R8 zero left", cap_l, 32'd0);
    chk("R8 zero right", cap_r, 32'd0);
    zero = 1'b0;

    // R9 disable
    @(negedge clk); dis = 1'b1;
    @(negedge clk);
    chk("R9 oe off", {31'd0, oe}, 32'd0);
    dis = 1'b0;
    @(negedge clk);
    chk("R9 oe back", {31'd0, oe}, 32'd1);

    // R5 data moves at the clock cycle after the falling edge is seen
    left = 24'h80_0000; right = 24'h00_0000;
    run_half(1'b0, 32, -1, 24'h0, dummy);
    run_half(1'b1, 32, -1, 24'h0, dummy);
    @(negedge clk); bclk = 1'b0; lrck = 1'b0;
    #1 chk("R5 before edge", {31'd0, sdata}, 32'd0);
    @(negedge clk);
    chk("R5 after edge", {31'd0, sdata}, 32'd1);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);

    // R7 frame errors: 32-clock frame flagged, valid halves clear it
    run_half(1'b1, 16, -1, 24'h0, dummy);
    run_half(1'b0, 16, -1, 24'h0, dummy);
    chk("R7 short frame", {31'd0, ferr}, 32'd1);
    run_half(1'b1, 16, -1, 24'h0, dummy);
    chk("R7 still flagged", {31'd0, ferr}, 32'd1);
    run_half(1'b0, 32, -1, 24'h0, dummy);
    run_half(1'b1, 32, -1, 24'h0, dummy);
    chk("R7 cleared", {31'd0, ferr}, 32'd0);
    run_half(1'b0, 40, -1, 24'h0, dummy);
    run_half(1'b1, 24, -1, 24'h0, dummy);
    chk("R7 long half", {31'd0, ferr}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule